// File: doc/BRIEF.md
# Prioritising Interrupt Distributor

This block collects interrupt requests from up to 64 interrupt numbers and steers each one to one or more of a small set of processor targets (two by default). Numbers 0 to 15 are raised only by software through a trigger register, numbers 16 to 31 are private lines that reach every processor, and numbers 32 and above are shared lines whose destination is chosen per number. Every number has its own enable bit, pending bit, 5-bit priority, trigger mode and, for shared lines, a processor mask.

For each processor the block presents the number and priority of the most urgent interrupt that is pending, enabled and aimed at that processor, together with a valid flag. A single master enable bit stops all forwarding. Software programs the block through a simple word-addressed register port. Writes take effect at the next clock edge. Read data appears on the clock edge after the read strobe.

Register regions sit at word address {region[3:0], index[5:0]}: region 0 control (bit 0 is the master enable), 1 enable-set, 2 enable-clear, 3 pending (write 1 to clear), 4 priority, 5 processor mask, 6 trigger mode, 7 software trigger. Regions 8 to 15 are unmapped.

Top module: `intDist`

## Requirements
- R1: When the master enable (region 0, index 0, bit 0, reset 0) is 0, no processor output is valid, whatever the pending state. Setting it back to 1 forwards pending requests again.
- R2: In the enable-set bank, index n bit b stands for number 32n+b. Writing 1 sets that enable and writing 0 changes nothing. A read of either the set bank or the clear bank returns the current enables.
- R3: Writing 1 to a bit of the enable-clear bank (same layout) clears that enable. A disabled number keeps its pending state and is forwarded again as soon as it is re-enabled.
- R4: Priority is one byte per number, at index number/4 and byte lane number mod 4. Only bits 7:3 are held and bits 2:0 read as 0. A lower value is more urgent. The output priority carries the held bits in 7:3 with zeros below.
- R5: Among candidates with equal priority, the lowest number wins. When a processor has no candidate, its valid flag is 0.
- R6: Trigger mode uses 2 bits per number, at index number/16 and bits (number mod 16)*2+1:(number mod 16)*2. The code 01 means level, active high, and 11 means rising edge. Numbers 0 to 15 always read 10 and ignore writes. For numbers 16 and up, bit 0 reads as 1 and only bit 1 is writable. Reset is 01 (level).
- R7: A level-mode number is pending exactly while its input was high at the last edge, and a pending-clear write has no effect on it. An edge-mode number becomes pending on a 0-to-1 input change and stays pending until 1 is written to its bit in the pending bank (index number/32, bit number mod 32).
- R8: A write to the software trigger register with a processor list in bits 23:16 and a number in bits 3:0 makes that number pending for each listed processor. List bits at or beyond the processor count are ignored. Numbers 0 to 15 read as pending while any processor holds them, and a pending-clear write clears them for all processors.
- R9: For shared numbers, a processor-mask byte (index number/4, lane number mod 4, bit c = processor c) selects the processors that may receive the interrupt. Only the low processor-count bits are held, and reset is 0. Private numbers go to every processor, and their mask bytes read 0.
- R10: Reads of fields for numbers at or beyond the number count, of the software trigger register and of unmapped regions return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 10 | Word address {region, index} |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| irqIn | input | NUM_IDS-16 | Hardware request lines for numbers 16 and up (index = number) |
| cpuIrqValid | output | NUM_CPUS | Per-processor candidate present |
| cpuIrqId | output | NUM_CPUS*clog2(NUM_IDS) | Per-processor winning number, processor c at slice c |
| cpuIrqPrio | output | NUM_CPUS*8 | Per-processor winning priority byte |

## Verification
The bench builds the block with its defaults: 64 numbers and 2 processors. With these values the second word of every per-number bank and the top trigger-mode word are fully populated, so shared numbers, the edge-mode word and the mask lanes are all reachable. Enable-bank index 2 and priority index 16 lie just beyond the implemented numbers, which exercises the read-as-zero and write-ignored paths. With two processors the bench can show one number reaching one processor but not the other, and show software list bits for processors 2 to 7 being dropped.

// File: rtl/intDistPkg.sv
package intDistPkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 6;
  localparam int REGION_W = 4;
  localparam int SGI_IDS  = 16;
  localparam int PRIV_END = 32;
  localparam int PRIO_W   = 5;

  localparam logic [REGION_W-1:0] RG_CTRL  = 4'd0;
  localparam logic [REGION_W-1:0] RG_SETEN = 4'd1;
  localparam logic [REGION_W-1:0] RG_CLREN = 4'd2;
  localparam logic [REGION_W-1:0] RG_PEND  = 4'd3;
  localparam logic [REGION_W-1:0] RG_PRIO  = 4'd4;
  localparam logic [REGION_W-1:0] RG_TGT   = 4'd5;
  localparam logic [REGION_W-1:0] RG_CFG   = 4'd6;
  localparam logic [REGION_W-1:0] RG_SGI   = 4'd7;

  // Strobes from the decoder to the state/datapath block
  typedef struct packed {
    logic                wrCtrl;
    logic                wrSetEn;
    logic                wrClrEn;
    logic                wrClrPend;
    logic                wrPrio;
    logic                wrTarget;
    logic                wrCfg;
    logic                wrSgi;
    logic                rdEn;
    logic [REGION_W-1:0] rdRegion;
    logic [IDX_W-1:0]    idx;
  } strobeT;
endpackage

// File: rtl/intDistCtrl.sv
module intDistCtrl
  import intDistPkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobeT            stb
);
  logic [REGION_W-1:0] region;
  logic [IDX_W-1:0]    idx;

  assign region = regAddr[ADDR_W-1:IDX_W];
  assign idx    = regAddr[IDX_W-1:0];

  always_comb begin
    stb          = '0;
    stb.idx      = idx;
    stb.rdEn     = regRdEn;
    stb.rdRegion = region;
    if (regWrEn) begin
      case (region)
        RG_CTRL:  stb.wrCtrl    = (idx == '0);
        RG_SETEN: stb.wrSetEn   = 1'b1;
        RG_CLREN: stb.wrClrEn   = 1'b1;
        RG_PEND:  stb.wrClrPend = 1'b1;
        RG_PRIO:  stb.wrPrio    = 1'b1;
        RG_TGT:   stb.wrTarget  = 1'b1;
        RG_CFG:   stb.wrCfg     = 1'b1;
        RG_SGI:   stb.wrSgi     = (idx == '0);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/intDistArb.sv
module intDistArb
  import intDistPkg::*;
#(
  parameter int NUM_IDS = 64,
  localparam int ID_W   = $clog2(NUM_IDS)
) (
  input  logic [NUM_IDS-1:0]             elig,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio,
  output logic                           valid,
  output logic [ID_W-1:0]                id,
  output logic [7:0]                     prioOut
);
  // Ascending scan with strict compare: equal priority keeps the lower number
  logic [PRIO_W:0] bestP;
  logic [ID_W-1:0] bestId;

  always_comb begin
    bestP  = {1'b1, {PRIO_W{1'b0}}};
    bestId = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (elig[i] && ({1'b0, prio[i]} < bestP)) begin
        bestP  = {1'b0, prio[i]};
        bestId = ID_W'(i);
      end
    end
  end

  assign valid   = ~bestP[PRIO_W];
  assign id      = valid ? bestId : '0;
  assign prioOut = valid ? {bestP[PRIO_W-1:0], 3'b000} : 8'd0;
endmodule

// File: rtl/intDistDatapath.sv
module intDistDatapath
  import intDistPkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 2,
  localparam int ID_W    = $clog2(NUM_IDS)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobeT                             stb,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic [NUM_IDS-1:SGI_IDS]           irqIn,
  output logic [DATA_W-1:0]                  rdData,
  output logic                               distEn,
  output logic [NUM_IDS-1:0]                 enableQ,
  output logic [NUM_CPUS-1:0]                cpuValid,
  output logic [NUM_CPUS-1:0][ID_W-1:0]      cpuId,
  output logic [NUM_CPUS-1:0][7:0]           cpuPrio
);
  logic [NUM_IDS-1:SGI_IDS]               pendLine;
  logic [NUM_IDS-1:SGI_IDS]               cfgEdge;
  logic [NUM_IDS-1:SGI_IDS]               irqPrev;
  logic [NUM_IDS-1:PRIV_END][NUM_CPUS-1:0] target;
  logic [NUM_IDS-1:0][PRIO_W-1:0]         prio;
  logic [NUM_CPUS-1:0][SGI_IDS-1:0]       sgiPend;
  logic [NUM_IDS-1:0]                     pendVec;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]       elig;
  logic [DATA_W-1:0]                      rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      distEn   <= 1'b0;
      enableQ  <= '0;
      pendLine <= '0;
      cfgEdge  <= '0;
      irqPrev  <= '0;
      target   <= '0;
      prio     <= '0;
      sgiPend  <= '0;
      rdData   <= '0;
    end else begin
      irqPrev <= irqIn;
      if (stb.rdEn) rdData <= rdNext;
      if (stb.wrCtrl) distEn <= wrData[0];
      for (int i = 0; i < NUM_IDS; i++) begin
        if (stb.wrSetEn && stb.idx == IDX_W'(i / 32) && wrData[i % 32])
          enableQ[i] <= 1'b1;
        else if (stb.wrClrEn && stb.idx == IDX_W'(i / 32) && wrData[i % 32])
          enableQ[i] <= 1'b0;
        if (stb.wrPrio && stb.idx == IDX_W'(i / 4))
          prio[i] <= wrData[(i % 4) * 8 + 3 +: PRIO_W];
      end
      for (int i = SGI_IDS; i < NUM_IDS; i++) begin
        if (cfgEdge[i]) begin
          if (irqIn[i] && !irqPrev[i])
            pendLine[i] <= 1'b1;
          else if (stb.wrClrPend && stb.idx == IDX_W'(i / 32) && wrData[i % 32])
            pendLine[i] <= 1'b0;
        end else begin
          pendLine[i] <= irqIn[i];
        end
        if (stb.wrCfg && stb.idx == IDX_W'(i / 16))
          cfgEdge[i] <= wrData[(i % 16) * 2 + 1];
      end
      for (int i = PRIV_END; i < NUM_IDS; i++) begin
        if (stb.wrTarget && stb.idx == IDX_W'(i / 4))
          target[i] <= wrData[(i % 4) * 8 +: NUM_CPUS];
      end
      for (int c = 0; c < NUM_CPUS; c++) begin
        for (int s = 0; s < SGI_IDS; s++) begin
          if (stb.wrSgi && wrData[16 + c] && wrData[3:0] == 4'(s))
            sgiPend[c][s] <= 1'b1;
          else if (stb.wrClrPend && stb.idx == '0 && wrData[s])
            sgiPend[c][s] <= 1'b0;
        end
      end
    end
  end

  // Combined pending view, as seen through the pending bank
  always_comb begin
    pendVec = '0;
    for (int s = 0; s < SGI_IDS; s++)
      for (int c = 0; c < NUM_CPUS; c++)
        pendVec[s] = pendVec[s] | sgiPend[c][s];
    for (int i = SGI_IDS; i < NUM_IDS; i++)
      pendVec[i] = pendLine[i];
  end

  // Per-processor candidates
  always_comb begin
    elig = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int s = 0; s < SGI_IDS; s++)
        elig[c][s] = distEn & enableQ[s] & sgiPend[c][s];
      for (int i = SGI_IDS; i < PRIV_END; i++)
        elig[c][i] = distEn & enableQ[i] & pendLine[i];
      for (int i = PRIV_END; i < NUM_IDS; i++)
        elig[c][i] = distEn & enableQ[i] & pendLine[i] & target[i][c];
    end
  end

  // Read multiplexer
  always_comb begin
    rdNext = '0;
    case (stb.rdRegion)
      RG_CTRL: if (stb.idx == '0) rdNext[0] = distEn;
      RG_SETEN, RG_CLREN:
        for (int i = 0; i < NUM_IDS; i++)
          if (stb.idx == IDX_W'(i / 32)) rdNext[i % 32] = enableQ[i];
      RG_PEND:
        for (int i = 0; i < NUM_IDS; i++)
          if (stb.idx == IDX_W'(i / 32)) rdNext[i % 32] = pendVec[i];
      RG_PRIO:
        for (int i = 0; i < NUM_IDS; i++)
          if (stb.idx == IDX_W'(i / 4)) rdNext[(i % 4) * 8 + 3 +: PRIO_W] = prio[i];
      RG_TGT:
        for (int i = PRIV_END; i < NUM_IDS; i++)
          if (stb.idx == IDX_W'(i / 4)) rdNext[(i % 4) * 8 +: NUM_CPUS] = target[i];
      RG_CFG: begin
        for (int s = 0; s < SGI_IDS; s++)
          if (stb.idx == IDX_W'(s / 16)) rdNext[(s % 16) * 2 +: 2] = 2'b10;
        for (int i = SGI_IDS; i < NUM_IDS; i++)
          if (stb.idx == IDX_W'(i / 16)) rdNext[(i % 16) * 2 +: 2] = {cfgEdge[i], 1'b1};
      end
      default: ;
    endcase
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    intDistArb #(.NUM_IDS(NUM_IDS)) u_arb (
      .elig    (elig[c]),
      .prio    (prio),
      .valid   (cpuValid[c]),
      .id      (cpuId[c]),
      .prioOut (cpuPrio[c])
    );
  end
endmodule

// File: rtl/intDist.sv
module intDist
  import intDistPkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 regWrEn,
  input  logic                                 regRdEn,
  input  logic [ADDR_W-1:0]                    regAddr,
  input  logic [DATA_W-1:0]                    regWrData,
  output logic [DATA_W-1:0]                    regRdData,
  input  logic [NUM_IDS-1:SGI_IDS]             irqIn,
  output logic [NUM_CPUS-1:0]                  cpuIrqValid,
  output logic [NUM_CPUS*$clog2(NUM_IDS)-1:0]  cpuIrqId,
  output logic [NUM_CPUS*8-1:0]                cpuIrqPrio
);
  localparam int ID_W = $clog2(NUM_IDS);

  strobeT                          stb;
  logic                            distEn;
  logic [NUM_IDS-1:0]              enableQ;
  logic [NUM_CPUS-1:0][ID_W-1:0]   cpuId;
  logic [NUM_CPUS-1:0][7:0]        cpuPrio;

  intDistCtrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  intDistDatapath #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .irqIn    (irqIn),
    .rdData   (regRdData),
    .distEn   (distEn),
    .enableQ  (enableQ),
    .cpuValid (cpuIrqValid),
    .cpuId    (cpuId),
    .cpuPrio  (cpuPrio)
  );

  assign cpuIrqId   = cpuId;
  assign cpuIrqPrio = cpuPrio;
endmodule

// File: rtl/intDistChk.sv
module intDistChk
  import intDistPkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_CPUS = 2,
  localparam int ID_W    = $clog2(NUM_IDS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       regRdEn,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [DATA_W-1:0]          regRdData,
  input logic                       distEn,
  input logic [NUM_IDS-1:0]         enableQ,
  input logic [NUM_CPUS-1:0]        cpuIrqValid,
  input logic [NUM_CPUS*ID_W-1:0]   cpuIrqId,
  input logic [NUM_CPUS*8-1:0]      cpuIrqPrio
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rstN)
      !distEn |-> !cpuIrqValid[c]);
    assert_only_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrqValid[c] |-> enableQ[cpuIrqId[c*ID_W +: ID_W]]);
    assert_prio_grain_R4: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrqValid[c] |-> (cpuIrqPrio[c*8 +: 3] == 3'b000));
    assert_id_range_R10: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrqValid[c] |-> (int'(cpuIrqId[c*ID_W +: ID_W]) < NUM_IDS));
  end

  assert_prio_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr[ADDR_W-1:IDX_W] == RG_PRIO) |=> ((regRdData & 32'h0707_0707) == '0));
  assert_sgi_cfg_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == {RG_CFG, 6'd0}) |=> (regRdData == 32'hAAAA_AAAA));
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr[ADDR_W-1:IDX_W] >= RG_SGI) |=> (regRdData == '0));
endmodule

bind intDist intDistChk #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .distEn      (distEn),
  .enableQ     (enableQ),
  .cpuIrqValid (cpuIrqValid),
  .cpuIrqId    (cpuIrqId),
  .cpuIrqPrio  (cpuIrqPrio)
);

// File: tb/intDist_bench.sv
`timescale 1ns/1ps
module intDist_bench;
  localparam int NI = 64;
  localparam int NC = 2;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [9:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NI-1:16] irqIn = '0;
  logic [NC-1:0] cpuIrqValid;
  logic [NC*IW-1:0] cpuIrqId;
  logic [NC*8-1:0]  cpuIrqPrio;

  int nChecks = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  intDist #(.NUM_IDS(NI), .NUM_CPUS(NC)) u_intDist (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqIn(irqIn), .cpuIrqValid(cpuIrqValid), .cpuIrqId(cpuIrqId),
    .cpuIrqPrio(cpuIrqPrio)
  );

  function automatic logic [9:0] ad(input int region, input int idx);
    return {4'(region), 6'(idx)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkCpu(input string req, input int c, input bit v, input int id, input int pr);
    chk({req, " valid"}, 32'(cpuIrqValid[c]), 32'(v));
    if (v) begin
      chk({req, " id"}, 32'(cpuIrqId[c*IW +: IW]), 32'(id));
      chk({req, " prio"}, 32'(cpuIrqPrio[c*8 +: 8]), 32'(pr));
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic setIrq(input int n, input logic v);
    @(negedge clk);
    irqIn[n] = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chkCpu("R5 reset cpu0", 0, 0, 0, 0);
    chkCpu("R5 reset cpu1", 1, 0, 0, 0);
    rd(ad(0, 0), d); chk("R1 reset master enable", d, 0);
    rd(ad(1, 0), d); chk("R2 reset enables", d, 0);
    rd(ad(6, 2), d); chk("R6 reset level mode", d, 32'h5555_5555);
  endtask

  task automatic testMasterEnable();
    wr(ad(1, 1), 32'h0000_0100);   // enable 40
    wr(ad(5, 10), 32'h0000_0001);  // 40 -> cpu0
    wr(ad(4, 10), 32'h0000_0050);  // prio 40 = 0x50
    setIrq(40, 1'b1);
    chkCpu("R1 master off", 0, 0, 0, 0);
    wr(ad(0, 0), 32'h1);
    chkCpu("R1 master on cpu0", 0, 1, 40, 8'h50);
    chkCpu("R9 mask excludes cpu1", 1, 0, 0, 0);
    wr(ad(0, 0), 32'h0);
    chkCpu("R1 master off again", 0, 0, 0, 0);
    wr(ad(0, 0), 32'h1);
  endtask

  task automatic testEnableBanks();
    logic [31:0] d;
    wr(ad(1, 1), 32'h0);
    rd(ad(1, 1), d); chk("R2 zero write no effect", d, 32'h100);
    wr(ad(2, 1), 32'h100);
    chkCpu("R3 disabled", 0, 0, 0, 0);
    rd(ad(2, 1), d); chk("R2 clear bank reads enables", d, 0);
    rd(ad(3, 1), d); chk("R3 pending kept", d, 32'h100);
    wr(ad(1, 1), 32'h100);
    chkCpu("R3 re-enable forwards", 0, 1, 40, 8'h50);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    wr(ad(1, 1), 32'h200);          // enable 41
    wr(ad(5, 10), 32'h0000_0101);   // 40,41 -> cpu0
    wr(ad(4, 10), 32'h0000_5750);   // 41 gets 0x57 -> held 0x50
    setIrq(41, 1'b1);
    chkCpu("R5 tie lowest number", 0, 1, 40, 8'h50);
    rd(ad(4, 10), d); chk("R4 low bits read zero", d, 32'h0000_5050);
    wr(ad(4, 10), 32'h0000_4850);
    chkCpu("R4 lower value wins", 0, 1, 41, 8'h48);
    @(negedge clk); irqIn[40] = 1'b0; irqIn[41] = 1'b0;
    @(negedge clk);
    chkCpu("R5 no candidate", 0, 0, 0, 0);
  endtask

  task automatic testTrigger();
    logic [31:0] d;
    wr(ad(6, 3), 32'hFFFF_FFFF);
    rd(ad(6, 3), d); chk("R6 edge mode readback", d, 32'hFFFF_FFFF);
    wr(ad(6, 0), 32'h0);
    rd(ad(6, 0), d); chk("R6 software numbers fixed", d, 32'hAAAA_AAAA);
    wr(ad(6, 1), 32'h0);
    rd(ad(6, 1), d); chk("R6 low bit read-only", d, 32'h5555_5555);
    wr(ad(1, 1), 32'h0004_0000);     // enable 50
    wr(ad(5, 12), 32'h0002_0000);    // 50 -> cpu1
    @(negedge clk); irqIn[50] = 1'b1;
    @(negedge clk); irqIn[50] = 1'b0;
    chkCpu("R7 edge sets pending", 1, 1, 50, 0);
    @(negedge clk);
    chkCpu("R7 edge pending held", 1, 1, 50, 0);
    wr(ad(3, 1), 32'h0004_0000);
    chkCpu("R7 edge cleared by write", 1, 0, 0, 0);
    setIrq(40, 1'b1);
    wr(ad(3, 1), 32'h0000_0100);
    chkCpu("R7 level ignores clear", 0, 1, 40, 8'h50);
    setIrq(40, 1'b0);
    chkCpu("R7 level follows input", 0, 0, 0, 0);
  endtask

  task automatic testSoftware();
    logic [31:0] d;
    wr(ad(1, 0), 32'h20);            // enable 5
    wr(ad(7, 0), 32'h0002_0005);     // 5 -> cpu1
    chkCpu("R8 listed cpu1", 1, 1, 5, 0);
    chkCpu("R8 unlisted cpu0", 0, 0, 0, 0);
    wr(ad(7, 0), 32'h0003_0005);
    chkCpu("R8 listed cpu0", 0, 1, 5, 0);
    rd(ad(3, 0), d); chk("R8 pending readback", d, 32'h20);
    rd(ad(7, 0), d); chk("R10 trigger reads zero", d, 0);
    wr(ad(3, 0), 32'h20);
    chkCpu("R8 clear cpu0", 0, 0, 0, 0);
    chkCpu("R8 clear cpu1", 1, 0, 0, 0);
    wr(ad(7, 0), 32'h0080_0005);
    chkCpu("R8 high list bit ignored cpu0", 0, 0, 0, 0);
    chkCpu("R8 high list bit ignored cpu1", 1, 0, 0, 0);
  endtask

  task automatic testTargets();
    logic [31:0] d;
    wr(ad(1, 0), 32'h0010_0000);     // enable 20
    setIrq(20, 1'b1);
    chkCpu("R9 private to cpu0", 0, 1, 20, 0);
    chkCpu("R9 private to cpu1", 1, 1, 20, 0);
    wr(ad(5, 5), 32'hFFFF_FFFF);
    rd(ad(5, 5), d); chk("R9 private mask reads zero", d, 0);
    setIrq(20, 1'b0);
    wr(ad(1, 1), 32'h2);             // enable 33
    setIrq(33, 1'b1);
    chkCpu("R9 empty mask cpu0", 0, 0, 0, 0);
    chkCpu("R9 empty mask cpu1", 1, 0, 0, 0);
    wr(ad(5, 8), 32'h0000_FF00);
    rd(ad(5, 8), d); chk("R9 mask width", d, 32'h0000_0300);
    chkCpu("R9 both cpu0", 0, 1, 33, 0);
    chkCpu("R9 both cpu1", 1, 1, 33, 0);
    setIrq(33, 1'b0);
  endtask

  task automatic testUnimplemented();
    logic [31:0] d;
    wr(ad(1, 2), 32'hFFFF_FFFF);
    rd(ad(1, 2), d); chk("R10 enable beyond count", d, 0);
    wr(ad(4, 16), 32'hFFFF_FFFF);
    rd(ad(4, 16), d); chk("R10 priority beyond count", d, 0);
    rd(ad(9, 0), d); chk("R10 unmapped region", d, 0);
    rd(ad(1, 1), d); chk("R10 implemented word intact", d, 32'h0004_0302);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMasterEnable();
    testEnableBanks();
    testPriority();
    testTrigger();
    testSoftware();
    testTargets();
    testUnimplemented();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule